// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

This block sits in a bus bridge between a PCI-style requester and an upstream memory port. It runs the fetch side of delayed reads. Each accepted read names a command class (plain read, read-line or read-multiple) and a start address. From that the block works out how many line fetches to issue upstream, walks the line addresses, and counts the fetches that complete. A read is held in one of a small set of delayed-request slots. The downstream side watches a per-slot reconnect flag, which tells it when the requester may come back and take data.

A control word, written through a single load strobe, sets the behaviour of each class. For each class it gives a prefetch depth, a reconnect threshold and a continuous-window switch. The word also holds a global enable, a switch that lets plain reads use the read-line settings, and the number of delayed requests that may be outstanding. In continuous mode, each line the downstream side hands to the requester opens room for one more upstream fetch, so the window slides forward. When an error completion arrives, fetching stops for that request. When a request is retired, its window closes and any fetches still in flight are drained.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: The control word resets to all zero and is replaced on a cycle with `cfg_we` high. Its layout is: bit 0 global enable, bit 1 plain-read prefetch, [4:2] line depth, [7:5] multiple depth, [10:8] line threshold, [13:11] multiple threshold, bit 14 line continuous, bit 15 multiple continuous, [17:16] request limit field. Commands are encoded as 0 plain, 1 read-line, 2 read-multiple and 3 treated as plain.
- R2: With the global enable clear, every request issues exactly one fetch. That fetch carries `up_whole_line`=1 for read-line and read-multiple, and 0 (requested word only) for plain reads. All depth, threshold and continuous fields are ignored.
- R3: With the global enable set, a plain read issues a single word fetch (`up_whole_line`=0) when plain-read prefetch is clear. When plain-read prefetch is set, it behaves exactly like a read-line.
- R4: With the global enable set, a read-line or read-multiple issues depth+1 fetches, all with `up_whole_line`=1. The first fetch is at the request address, and each later one is at the previous address aligned down to a LINE_BYTES boundary plus LINE_BYTES.
- R5: When the line depth is larger than the multiple depth, the line depth in use is the multiple depth.
- R6: A slot's reconnect flag is high exactly while the count of error-free completions is at least T. T is 1 when the class threshold is 0 or prefetching does not apply; otherwise T is the smaller of the threshold and the total line count.
- R7: With the class's continuous bit set, each `dn_line_taken` pulse for the slot adds exactly one further fetch, continuing the address sequence. With the bit clear, the pulse has no effect.
- R8: At most min(field+1, NSLOT) slots are busy. A request that arrives when that many are busy, or no slot is free, gets `req_retry`=1 in the same cycle, and no slot is taken. An accepted request gets `req_accept`=1 and `req_slot` set to the lowest free slot.
- R9: An error completion stops all further fetches for the slot, raises its error flag, and raises its reconnect flag.
- R10: Retiring a slot drops its reconnect flag and stops issuing at once. The slot stays busy until its in-flight fetches have completed; their completions are discarded.
- R11: At most one fetch is offered per cycle. When several slots want to fetch, the lowest-numbered slot is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the control word |
| cfg_wdata | input | 18 | Control word value |
| req_valid | input | 1 | New read presented this cycle |
| req_cmd | input | 2 | Command class of the new read |
| req_addr | input | AW | Start address of the new read |
| req_accept | output | 1 | Read taken into a slot |
| req_retry | output | 1 | Read refused, requester must retry |
| req_slot | output | SW | Slot given to an accepted read |
| up_valid | output | 1 | Fetch offered upstream |
| up_ready | input | 1 | Upstream takes the offered fetch |
| up_addr | output | AW | Fetch address |
| up_whole_line | output | 1 | 1: fetch to end of line, 0: requested word only |
| up_slot | output | SW | Slot owning the offered fetch |
| up_done | input | 1 | A fetch completed |
| up_done_err | input | 1 | The completion carried an error |
| up_done_slot | input | SW | Slot of the completion |
| dn_line_taken | input | 1 | One line handed to the requester |
| dn_taken_slot | input | SW | Slot of that line |
| dn_retire | input | 1 | Request retired or requester gone |
| dn_retire_slot | input | SW | Slot being retired |
| slot_busy | output | NSLOT | Slot holds a request or is draining |
| slot_reconnect | output | NSLOT | Requester may reconnect for the slot |
| slot_err | output | NSLOT | Slot saw an error completion |

## Verification
Accept and retry are combinational, so they are read a moment after the request is driven, in the same cycle. A fetch whose state was loaded at one edge is offered from that edge on, and it is taken at the next edge if `up_ready` is high. A completion, a taken line or a retire driven before an edge changes the reconnect, error and busy flags right after that edge. The bench drives every input on the falling edge and samples outputs before the next rising edge. It keeps its own counts of offered fetches and applied completions, and compares reconnect against the threshold count on every cycle of a request.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [1:0] {
    CMD_RD     = 2'd0,
    CMD_RDLINE = 2'd1,
    CMD_RDMULT = 2'd2,
    CMD_RSVD   = 2'd3
  } rd_cmd_e;

  // control word, bit 0 is the global enable
  typedef struct packed {
    logic [1:0] dreq;
    logic       mult_cont;
    logic       line_cont;
    logic [2:0] mult_init;
    logic [2:0] line_init;
    logic [2:0] mult_cnt;
    logic [2:0] line_cnt;
    logic       plain_pf;
    logic       pf_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // per-request fetch plan
  typedef struct packed {
    logic [3:0] total;
    logic [3:0] thr;
    logic       cont;
    logic       whole;
  } plan_t;

endpackage

// File: rtl/rpf_plan.sv
module rpf_plan
  import rpf_pkg::*;
(
  input  logic       pf_en,
  input  logic       plain_pf,
  input  logic [2:0] line_cnt,
  input  logic [2:0] mult_cnt,
  input  logic [2:0] line_init,
  input  logic [2:0] mult_init,
  input  logic       line_cont,
  input  logic       mult_cont,
  input  rd_cmd_e    cmd,
  output plan_t      plan
);

  logic [2:0] line_eff;
  logic [2:0] init_sel;
  logic       is_mult;
  logic       is_line;

  // line depth may not exceed multiple depth
  assign line_eff = (line_cnt > mult_cnt) ? mult_cnt : line_cnt;
  assign is_mult  = (cmd == CMD_RDMULT);
  assign is_line  = (cmd == CMD_RDLINE) || (!is_mult && plain_pf);

  always_comb begin
    plan.total = 4'd1;
    plan.cont  = 1'b0;
    plan.whole = is_mult || (cmd == CMD_RDLINE);
    init_sel   = 3'd0;
    if (pf_en && is_mult) begin
      plan.total = {1'b0, mult_cnt} + 4'd1;
      plan.cont  = mult_cont;
      plan.whole = 1'b1;
      init_sel   = mult_init;
    end else if (pf_en && is_line) begin
      plan.total = {1'b0, line_eff} + 4'd1;
      plan.cont  = line_cont;
      plan.whole = 1'b1;
      init_sel   = line_init;
    end
    if (init_sel == 3'd0) begin
      plan.thr = 4'd1;
    end else if ({1'b0, init_sel} > plan.total) begin
      plan.thr = plan.total;
    end else begin
      plan.thr = {1'b0, init_sel};
    end
  end

endmodule

// File: rtl/rpf_slot.sv
module rpf_slot
  import rpf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  plan_t         plan,
  input  logic          grant,
  input  logic          done,
  input  logic          done_err,
  input  logic          taken,
  input  logic          retire,
  output logic          want,
  output logic [AW-1:0] addr,
  output logic          whole,
  output logic          busy,
  output logic          reconnect,
  output logic          err
);

  localparam int LW = $clog2(LINE_BYTES);

  logic          active_q, active_n;
  logic          drain_q,  drain_n;
  logic          err_q,    err_n;
  logic          cont_q,   cont_n;
  logic          whole_q,  whole_n;
  logic [3:0]    rem_q,    rem_n;
  logic [3:0]    ok_q,     ok_n;
  logic [3:0]    infl_q,   infl_n;
  logic [3:0]    thr_q,    thr_n;
  logic [AW-1:0] addr_q,   addr_n;
  logic [AW-1:0] line_base;
  logic          upd_en;

  assign line_base = {addr_q[AW-1:LW], {LW{1'b0}}};
  assign upd_en    = start | grant | done | taken | retire | drain_q;

  always_comb begin
    active_n = active_q;
    drain_n  = drain_q;
    err_n    = err_q;
    cont_n   = cont_q;
    whole_n  = whole_q;
    rem_n    = rem_q;
    ok_n     = ok_q;
    infl_n   = infl_q;
    thr_n    = thr_q;
    addr_n   = addr_q;
    if (start) begin
      active_n = 1'b1;
      drain_n  = 1'b0;
      err_n    = 1'b0;
      cont_n   = plan.cont;
      whole_n  = plan.whole;
      rem_n    = plan.total;
      ok_n     = 4'd0;
      infl_n   = 4'd0;
      thr_n    = plan.thr;
      addr_n   = start_addr;
    end else begin
      infl_n = infl_q + {3'd0, grant} - {3'd0, done};
      if (grant) begin
        rem_n   = rem_q - 4'd1;
        addr_n  = line_base + AW'(LINE_BYTES);
        whole_n = 1'b1;
      end
      if (taken && active_q && cont_q && !err_q) begin
        rem_n = rem_n + 4'd1;
      end
      if (done && active_q) begin
        if (done_err) begin
          err_n = 1'b1;
          rem_n = 4'd0;
        end else if (ok_q != 4'hF) begin
          ok_n = ok_q + 4'd1;
        end
      end
      if (retire && active_q) begin
        active_n = 1'b0;
        rem_n    = 4'd0;
        drain_n  = (infl_n != 4'd0);
      end else if (drain_q && (infl_n == 4'd0)) begin
        drain_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      drain_q  <= 1'b0;
      err_q    <= 1'b0;
      cont_q   <= 1'b0;
      whole_q  <= 1'b0;
      rem_q    <= 4'd0;
      ok_q     <= 4'd0;
      infl_q   <= 4'd0;
      thr_q    <= 4'd1;
      addr_q   <= '0;
    end else if (upd_en) begin
      active_q <= active_n;
      drain_q  <= drain_n;
      err_q    <= err_n;
      cont_q   <= cont_n;
      whole_q  <= whole_n;
      rem_q    <= rem_n;
      ok_q     <= ok_n;
      infl_q   <= infl_n;
      thr_q    <= thr_n;
      addr_q   <= addr_n;
    end
  end

  assign want      = active_q && !err_q && (rem_q != 4'd0);
  assign addr      = addr_q;
  assign whole     = whole_q;
  assign busy      = active_q | drain_q;
  assign reconnect = active_q && (err_q || (ok_q >= thr_q));
  assign err       = err_q;

  // R11: the arbiter only grants a slot that still has budget
  a_r11_grant_has_budget: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (active_q && !err_q && (rem_q != 4'd0)));

  // R6: completion count never falls while a request stays live
  a_r6_ok_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(start)) |-> (ok_q >= $past(ok_q)));

  // R10: retire closes reconnect and issue on the next cycle
  a_r10_retire_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && active_q && !start) |=> (!reconnect && !want));

  // R9: an error completion silences the slot and opens reconnect
  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err && active_q && !retire && !start) |=> (err && reconnect && !want));

endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
  import rpf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int NSLOT      = 4,
  localparam int SW        = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [17:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [AW-1:0]    req_addr,
  output logic             req_accept,
  output logic             req_retry,
  output logic [SW-1:0]    req_slot,
  output logic             up_valid,
  input  logic             up_ready,
  output logic [AW-1:0]    up_addr,
  output logic             up_whole_line,
  output logic [SW-1:0]    up_slot,
  input  logic             up_done,
  input  logic             up_done_err,
  input  logic [SW-1:0]    up_done_slot,
  input  logic             dn_line_taken,
  input  logic [SW-1:0]    dn_taken_slot,
  input  logic             dn_retire,
  input  logic [SW-1:0]    dn_retire_slot,
  output logic [NSLOT-1:0] slot_busy,
  output logic [NSLOT-1:0] slot_reconnect,
  output logic [NSLOT-1:0] slot_err
);

  localparam int CW = (NSLOT > 4) ? $clog2(NSLOT + 1) : 3;

  cfg_t                cfg_q;
  plan_t               plan;
  logic [CW-1:0]       lim_raw;
  logic [CW-1:0]       lim;
  logic [CW-1:0]       busy_cnt;
  logic                any_free;
  logic [SW-1:0]       free_idx;
  logic [NSLOT-1:0]    want_vec;
  logic [NSLOT-1:0]    grant_vec;
  logic [NSLOT-1:0]    whole_vec;
  logic [AW-1:0]       addr_arr [NSLOT];
  logic [SW-1:0]       pick_idx;

  // control word register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_t'(cfg_wdata);
    end
  end

  rpf_plan u_plan (
    .pf_en     (cfg_q.pf_en),
    .plain_pf  (cfg_q.plain_pf),
    .line_cnt  (cfg_q.line_cnt),
    .mult_cnt  (cfg_q.mult_cnt),
    .line_init (cfg_q.line_init),
    .mult_init (cfg_q.mult_init),
    .line_cont (cfg_q.line_cont),
    .mult_cont (cfg_q.mult_cont),
    .cmd       (rd_cmd_e'(req_cmd)),
    .plan      (plan)
  );

  // outstanding limit
  assign lim_raw = CW'(cfg_q.dreq) + CW'(1);
  assign lim     = (lim_raw > CW'(NSLOT)) ? CW'(NSLOT) : lim_raw;

  always_comb begin
    busy_cnt = '0;
    any_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      busy_cnt = busy_cnt + CW'(slot_busy[i]);
      if (!slot_busy[i] && !any_free) begin
        any_free = 1'b1;
        free_idx = SW'(i);
      end
    end
  end

  assign req_accept = req_valid && any_free && (busy_cnt < lim);
  assign req_retry  = req_valid && !req_accept;
  assign req_slot   = free_idx;

  // fixed-priority fetch arbiter, lowest slot first
  always_comb begin
    grant_vec = '0;
    pick_idx  = '0;
    up_valid  = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (want_vec[i] && !up_valid) begin
        up_valid     = 1'b1;
        pick_idx     = SW'(i);
        grant_vec[i] = up_ready;
      end
    end
  end

  assign up_slot       = pick_idx;
  assign up_addr       = addr_arr[pick_idx];
  assign up_whole_line = whole_vec[pick_idx];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit_start, hit_done, hit_taken, hit_retire;
    assign hit_start  = req_accept && (free_idx == SW'(g));
    assign hit_done   = up_done && (up_done_slot == SW'(g));
    assign hit_taken  = dn_line_taken && (dn_taken_slot == SW'(g));
    assign hit_retire = dn_retire && (dn_retire_slot == SW'(g));

    rpf_slot #(
      .AW         (AW),
      .LINE_BYTES (LINE_BYTES)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (hit_start),
      .start_addr (req_addr),
      .plan       (plan),
      .grant      (grant_vec[g]),
      .done       (hit_done),
      .done_err   (up_done_err),
      .taken      (hit_taken),
      .retire     (hit_retire),
      .want       (want_vec[g]),
      .addr       (addr_arr[g]),
      .whole      (whole_vec[g]),
      .busy       (slot_busy[g]),
      .reconnect  (slot_reconnect[g]),
      .err        (slot_err[g])
    );
  end

  // R8: the allocator hands out only a slot that is idle
  a_r8_alloc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> !slot_busy[free_idx]);

  // R8: accept and retry never coincide
  a_r8_accept_xor_retry: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_accept && req_retry));

  // R11: at most one slot granted per cycle
  a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R11: a grant is given only with the upstream ready and an offer out
  a_r11_grant_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> (up_valid && up_ready));

endmodule

// File: tb/sim_rd_prefetch_ctrl.sv
`timescale 1ns/1ps
module sim_rd_prefetch_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [17:0] cfg_wdata;
  logic        req_valid;
  logic [1:0]  req_cmd;
  logic [31:0] req_addr;
  logic        req_accept, req_retry;
  logic [1:0]  req_slot;
  logic        up_valid, up_ready;
  logic [31:0] up_addr;
  logic        up_whole_line;
  logic [1:0]  up_slot;
  logic        up_done, up_done_err;
  logic [1:0]  up_done_slot;
  logic        dn_line_taken;
  logic [1:0]  dn_taken_slot;
  logic        dn_retire;
  logic [1:0]  dn_retire_slot;
  logic [3:0]  slot_busy, slot_reconnect, slot_err;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  rd_prefetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_accept(req_accept), .req_retry(req_retry), .req_slot(req_slot),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_whole_line(up_whole_line), .up_slot(up_slot),
    .up_done(up_done), .up_done_err(up_done_err), .up_done_slot(up_done_slot),
    .dn_line_taken(dn_line_taken), .dn_taken_slot(dn_taken_slot),
    .dn_retire(dn_retire), .dn_retire_slot(dn_retire_slot),
    .slot_busy(slot_busy), .slot_reconnect(slot_reconnect), .slot_err(slot_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk_cfg(input bit pf, input bit ppf, input int lc, input int mc,
                                         input int li, input int mi, input bit lct, input bit mct,
                                         input int dq);
    return {dq[1:0], mct, lct, mi[2:0], li[2:0], mc[2:0], lc[2:0], ppf, pf};
  endfunction

  task automatic write_cfg(input logic [17:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request on an idle block, served with one completion per cycle
  task automatic run_one(input int cmd, input logic [31:0] a, input int total, input int thr,
                         input bit whole, input int n_taken, input bit cont, input string tag);
    int issued = 0;
    int dones  = 0;
    int pend   = 0;
    int exp_f;
    logic [31:0] ea;
    ea    = a;
    exp_f = total + (cont ? n_taken : 0);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd[1:0]; req_addr = a;
    #1;
    chk(req_accept === 1'b1, {"R8 accept ", tag}, req_accept, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      chk(slot_reconnect[0] == (dones >= thr), {"R6 reconnect ", tag}, slot_reconnect[0], dones >= thr);
      if (up_valid) begin
        chk(up_addr == ea, {"R4 address ", tag}, up_addr, ea);
        chk(up_whole_line == ((issued == 0) ? whole : 1'b1), {"R2 R3 extent ", tag},
            up_whole_line, (issued == 0) ? whole : 1'b1);
        issued++;
        ea = (ea & ~32'd63) + 32'd64;
      end
      up_done = (pend > 0);
      if (pend > 0) begin
        pend--;
        dones++;
      end
      if (up_valid) pend++;
      dn_line_taken = (c >= 12) && (c < 12 + n_taken);
      @(negedge clk);
    end
    up_done = 1'b0; dn_line_taken = 1'b0;
    chk(issued == exp_f, {"R4 R5 R7 fetch count ", tag}, issued, exp_f);
    dn_retire = 1'b1;
    @(negedge clk);
    dn_retire = 1'b0;
    chk(slot_busy == 4'd0, {"R10 free after retire ", tag}, slot_busy, 0);
  endtask

  function automatic void expect_plan(input bit pf, input bit ppf, input int cmd, input int lc,
                                      input int mc, input int li, input int mi,
                                      output int total, output int thr, output bit whole);
    int eff;
    int init;
    eff   = (lc > mc) ? mc : lc;
    total = 1;
    init  = 0;
    whole = (cmd == 1) || (cmd == 2);
    if (pf && cmd == 2) begin
      total = mc + 1; init = mi; whole = 1'b1;
    end else if (pf && (cmd == 1 || ppf)) begin
      total = eff + 1; init = li; whole = 1'b1;
    end
    thr = (init == 0) ? 1 : ((init > total) ? total : init);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int t, th;
    bit w;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; req_valid = 0; req_cmd = 0; req_addr = '0;
    up_ready = 1'b1; up_done = 0; up_done_err = 0; up_done_slot = 0;
    dn_line_taken = 0; dn_taken_slot = 0; dn_retire = 0; dn_retire_slot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(slot_busy == 0, "R1 busy after reset", slot_busy, 0);
    chk(up_valid == 0, "R1 no fetch after reset", up_valid, 0);
    // R1 R2: default word means no prefetch, a read-multiple fetches one line
    run_one(2, 32'h0000_1234, 1, 1, 1'b1, 0, 1'b0, "default");

    // R8: default limit is one request; extra is retried and not queued
    up_ready = 1'b0;
    @(negedge clk);
    req_valid = 1; req_cmd = 1; req_addr = 32'h100;
    #1;
    chk(req_accept && req_slot == 0, "R8 first accept", {req_accept, req_slot}, 3'b100);
    @(negedge clk);
    req_addr = 32'h200;
    #1;
    chk(req_retry == 1 && req_accept == 0, "R8 retry at limit", req_retry, 1);
    @(negedge clk);
    req_valid = 0;
    chk(slot_busy == 4'b0001, "R8 retried not queued", slot_busy, 1);
    write_cfg(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 1));
    req_valid = 1; req_addr = 32'h300;
    #1;
    chk(req_accept && req_slot == 1, "R8 second slot", {req_accept, req_slot}, 3'b101);
    @(negedge clk);
    req_addr = 32'h400;
    #1;
    chk(req_retry == 1, "R8 retry at limit two", req_retry, 1);
    @(negedge clk);
    req_valid = 0;
    chk(slot_busy == 4'b0011, "R8 two busy", slot_busy, 3);
    chk(up_valid && up_slot == 0, "R11 lowest slot first", up_slot, 0);
    up_ready = 1'b1;
    @(negedge clk);
    up_ready = 1'b0;
    chk(up_valid && up_slot == 1 && up_addr == 32'h300, "R11 next slot offered", up_addr, 32'h300);
    up_done = 1; up_done_slot = 0;
    dn_retire = 1; dn_retire_slot = 1;
    @(negedge clk);
    up_done = 0; dn_retire_slot = 0;
    @(negedge clk);
    dn_retire = 0;
    chk(slot_busy == 0, "R10 both released", slot_busy, 0);
    up_ready = 1'b1;

    // R2: global enable clear ignores all other fields
    write_cfg(mk_cfg(0, 1, 5, 7, 3, 3, 1, 1, 0));
    for (int c = 0; c < 4; c++)
      run_one(c, 32'h0000_2010 + c * 4, 1, 1, (c == 1 || c == 2), 2, 1'b0, "R2 off");

    // R3 R4 R5 R6: sweep depths, thresholds and classes
    for (int ppf = 0; ppf < 2; ppf++)
      for (int cmd = 0; cmd < 3; cmd++)
        for (int lc = 0; lc < 8; lc++)
          for (int mc = 0; mc < 8; mc++) begin
            int li, mi;
            li = (lc * 3 + mc) % 8;
            mi = (mc * 5 + lc) % 8;
            write_cfg(mk_cfg(1, ppf[0], lc, mc, li, mi, 0, 0, 0));
            expect_plan(1, ppf[0], cmd, lc, mc, li, mi, t, th, w);
            run_one(cmd, 32'h0001_0000 + lc * 32'h1000 + mc * 8 + 4, t, th, w, 2, 1'b0, "sweep");
          end

    // R7: continuous window per class
    write_cfg(mk_cfg(1, 0, 2, 7, 2, 0, 1, 0, 0));
    run_one(1, 32'h0003_0020, 3, 2, 1'b1, 3, 1'b1, "R7 line cont");
    write_cfg(mk_cfg(1, 0, 2, 3, 0, 4, 0, 1, 0));
    run_one(2, 32'h0004_0008, 4, 4, 1'b1, 4, 1'b1, "R7 mult cont");
    run_one(1, 32'h0004_0100, 3, 1, 1'b1, 4, 1'b0, "R7 line not cont");

    // R9 R10: error stops fetching, retire drains in-flight fetch
    write_cfg(mk_cfg(1, 0, 3, 3, 0, 0, 0, 0, 0));
    @(negedge clk);
    req_valid = 1; req_cmd = 1; req_addr = 32'h0005_0000;
    @(negedge clk);
    req_valid = 0;
    chk(up_valid == 1, "R4 first fetch", up_valid, 1);
    @(negedge clk);
    up_done = 1; up_done_err = 1; up_done_slot = 0;
    @(negedge clk);
    up_done = 0; up_done_err = 0;
    chk(slot_err[0] == 1, "R9 error flag", slot_err[0], 1);
    chk(slot_reconnect[0] == 1, "R9 reconnect on error", slot_reconnect[0], 1);
    begin
      int extra = 0;
      for (int c = 0; c < 6; c++) begin
        if (up_valid) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R9 no fetch after error", extra, 0);
    end
    dn_retire = 1; dn_retire_slot = 0;
    @(negedge clk);
    dn_retire = 0;
    chk(slot_busy[0] == 1, "R10 draining", slot_busy[0], 1);
    chk(slot_reconnect[0] == 0, "R10 reconnect dropped", slot_reconnect[0], 0);
    up_done = 1;
    @(negedge clk);
    up_done = 0;
    chk(slot_busy[0] == 0, "R10 drained", slot_busy[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule